// File: doc/BRIEF.md
# Microcoded Shared-Bus Processor Core

A compact 32-bit load/store processor core that executes every instruction as a sequence of register transfers. All transfers go over one 32-bit bus. A microcode sequencer steps through a read-only control store. Each control word names the single unit that drives the bus in that cycle: the immediate extender, the ALU, the register file or memory. It also names the registers that capture the bus value: the instruction register, operand latch A, operand latch B and the memory-address register. The register file has 32 general registers plus the program counter, which sits at index 32 and is reached through the same register port.

Instruction fetch copies the program counter into both the memory-address register and latch A in one cycle. It then loads the instruction register from memory, stalling while memory reports busy. Next it loads latch B with the constant 4, writes the ALU sum back to the program counter, and dispatches on the opcode. The execute routines cover register-register arithmetic and logic, add-immediate, branch-on-equal, word load and word store. The branch routine reads the ALU zero flag. Memory is external and uses a simple request/busy handshake: an access is accepted on the rising edge where busy is low, and read data must be valid in that same cycle.

Top module: `ucode_bus_core`

## Requirements
- R1: While reset is high, mem_req and mem_we stay low. The first memory request after reset is a read at address RESET_PC (default 0).
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and imm [15:0]. Opcodes 0, 1, 2 and 3 write rd with rs+rt, rs-rt, rs AND rt and rs OR rt, all modulo 2^32.
- R3: Opcode 8 writes rt with rs plus the sign-extended imm.
- R4: Register 0 always reads as zero, and every write to it is discarded.
- R5: Opcode 4 compares rs and rt. If they are equal, the next PC is PC+4+sext(imm)*4; otherwise it is PC+4. The word 0x1000FFFF is therefore a jump to itself.
- R6: Opcode 35 loads into rt, and opcode 43 stores rt to, the byte address rs+sext(imm). Memory is word-wide.
- R7: An access completes only on a clock edge where mem_busy is low. While busy holds it off, mem_req, mem_we and mem_addr stay unchanged. The results a program leaves in registers and memory do not depend on the busy pattern.
- R8: With mem_busy held low, instruction fetch reads of successive instructions are exactly 7 cycles apart when the earlier instruction is a register-register operation or an add-immediate.
- R9: At most one unit drives the shared bus in any cycle. During a store, mem_wdata carries the value of rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access requested this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | DW | Byte address, taken from the memory-address register |
| mem_wdata | output | DW | Write data, equal to the bus value |
| mem_rdata | input | DW | Read data, valid in the accepting cycle |
| mem_busy | input | 1 | Memory cannot accept the access this cycle |

## Verification
The bench builds the core with its defaults: 32-bit data, 32 general registers with the program counter at index 32, and a reset PC of 0. Full 5-bit register fields and 16-bit immediates are therefore reachable, as are the all-ones and sign-boundary values. The program sits in a 256-word memory model. Random programs over registers 0 to 7 exercise register-0 writes, short forward branches and load/store traffic. Each program runs once with busy held low and once with busy drawn at random. The results are compared against an instruction-level model kept in the bench.

// File: rtl/ubc_pkg.sv
package ubc_pkg;

  localparam int UA_W = 6;

  typedef enum logic [1:0] {SQ_NEXT, SQ_DISP, SQ_BZ, SQ_WAIT} seq_mode_e;
  typedef enum logic [1:0] {AL_ADD, AL_SUB, AL_AND, AL_OR} alu_op_e;
  typedef enum logic [1:0] {EX_SEXT, EX_ZEXT, EX_SHL2, EX_FOUR} ext_sel_e;
  typedef enum logic [2:0] {RS_RD, RS_RT, RS_RS, RS_LINK, RS_PC} reg_sel_e;

  // 17 datapath control bits followed by the sequencing fields
  typedef struct packed {
    logic      ld_ir;
    logic      ld_a;
    logic      ld_b;
    logic      ld_ma;
    logic      en_imm;
    logic      en_alu;
    logic      en_reg;
    logic      en_mem;
    logic      reg_wr;
    logic      mem_wr;
    alu_op_e   alu_op;
    ext_sel_e  ext;
    reg_sel_e  rsel;
    seq_mode_e mode;
    logic [UA_W-1:0] nxt;
  } uword_t;

endpackage

// File: rtl/ubc_alu.sv
module ubc_alu import ubc_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (op)
      AL_ADD:  y = a + b;
      AL_SUB:  y = a - b;
      AL_AND:  y = a & b;
      default: y = a | b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/ubc_regfile.sv
module ubc_regfile #(
  parameter int          DW       = 32,
  parameter int          NREG     = 32,
  parameter logic [DW-1:0] RESET_PC = '0,
  localparam int         IW       = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  // entries 0..NREG-1 are general registers, entry NREG is the program counter
  logic [DW-1:0] regs [NREG+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= NREG; i++) regs[i] <= '0;
      regs[NREG] <= RESET_PC;
    end else if (wr_en && idx != '0) begin
      regs[idx] <= wr_data;
    end
  end

  assign rd_data = (idx == '0) ? '0 : regs[idx];

  a_r4_zero_reads: assert property (@(posedge clk) disable iff (rst)
    (idx == '0) |-> (rd_data == '0));

  a_r5_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    regs[NREG][1:0] == 2'b00);
endmodule

// File: rtl/ubc_useq.sv
module ubc_useq import ubc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       zero,
  input  logic       busy,
  output uword_t     uw,
  output logic       go
);
  logic [UA_W-1:0] uaddr, uaddr_n;

  function automatic logic [UA_W-1:0] dispatch(input logic [5:0] op);
    case (op)
      6'd0:    return UA_W'(4);
      6'd1:    return UA_W'(7);
      6'd2:    return UA_W'(10);
      6'd3:    return UA_W'(13);
      6'd8:    return UA_W'(16);
      6'd4:    return UA_W'(19);
      6'd43:   return UA_W'(25);
      6'd35:   return UA_W'(29);
      default: return '0;
    endcase
  endfunction

  function automatic uword_t urom(input logic [UA_W-1:0] a);
    uword_t w;
    int     k;
    w = '0;
    k = int'(a) - 4;
    if (a >= UA_W'(4) && a <= UA_W'(15)) begin
      // four register-register routines of three words each
      w.nxt = UA_W'(int'(a) + 1);
      case (k % 3)
        0: begin w.rsel = RS_RS; w.en_reg = 1'b1; w.ld_a = 1'b1; end
        1: begin w.rsel = RS_RT; w.en_reg = 1'b1; w.ld_b = 1'b1; end
        default: begin
          w.alu_op = alu_op_e'(2'(k / 3));
          w.en_alu = 1'b1; w.rsel = RS_RD; w.reg_wr = 1'b1; w.nxt = '0;
        end
      endcase
    end else begin
      case (a)
        UA_W'(0):  begin w.rsel = RS_PC; w.en_reg = 1'b1; w.ld_ma = 1'b1; w.ld_a = 1'b1; w.nxt = UA_W'(1); end
        UA_W'(1):  begin w.en_mem = 1'b1; w.ld_ir = 1'b1; w.mode = SQ_WAIT; w.nxt = UA_W'(2); end
        UA_W'(2):  begin w.ext = EX_FOUR; w.en_imm = 1'b1; w.ld_b = 1'b1; w.nxt = UA_W'(3); end
        UA_W'(3):  begin w.en_alu = 1'b1; w.rsel = RS_PC; w.reg_wr = 1'b1; w.mode = SQ_DISP; end
        // add immediate
        UA_W'(16): begin w.rsel = RS_RS; w.en_reg = 1'b1; w.ld_a = 1'b1; w.nxt = UA_W'(17); end
        UA_W'(17): begin w.en_imm = 1'b1; w.ld_b = 1'b1; w.nxt = UA_W'(18); end
        UA_W'(18): begin w.en_alu = 1'b1; w.rsel = RS_RT; w.reg_wr = 1'b1; end
        // branch on equal
        UA_W'(19): begin w.rsel = RS_RS; w.en_reg = 1'b1; w.ld_a = 1'b1; w.nxt = UA_W'(20); end
        UA_W'(20): begin w.rsel = RS_RT; w.en_reg = 1'b1; w.ld_b = 1'b1; w.nxt = UA_W'(21); end
        UA_W'(21): begin w.alu_op = AL_SUB; w.mode = SQ_BZ; w.nxt = UA_W'(22); end
        UA_W'(22): begin w.rsel = RS_PC; w.en_reg = 1'b1; w.ld_a = 1'b1; w.nxt = UA_W'(23); end
        UA_W'(23): begin w.ext = EX_SHL2; w.en_imm = 1'b1; w.ld_b = 1'b1; w.nxt = UA_W'(24); end
        UA_W'(24): begin w.en_alu = 1'b1; w.rsel = RS_PC; w.reg_wr = 1'b1; end
        // store word
        UA_W'(25): begin w.rsel = RS_RS; w.en_reg = 1'b1; w.ld_a = 1'b1; w.nxt = UA_W'(26); end
        UA_W'(26): begin w.en_imm = 1'b1; w.ld_b = 1'b1; w.nxt = UA_W'(27); end
        UA_W'(27): begin w.en_alu = 1'b1; w.ld_ma = 1'b1; w.nxt = UA_W'(28); end
        UA_W'(28): begin w.rsel = RS_RT; w.en_reg = 1'b1; w.mem_wr = 1'b1; w.mode = SQ_WAIT; end
        // load word
        UA_W'(29): begin w.rsel = RS_RS; w.en_reg = 1'b1; w.ld_a = 1'b1; w.nxt = UA_W'(30); end
        UA_W'(30): begin w.en_imm = 1'b1; w.ld_b = 1'b1; w.nxt = UA_W'(31); end
        UA_W'(31): begin w.en_alu = 1'b1; w.ld_ma = 1'b1; w.nxt = UA_W'(32); end
        UA_W'(32): begin w.en_mem = 1'b1; w.rsel = RS_RT; w.reg_wr = 1'b1; w.mode = SQ_WAIT; end
        default: ;
      endcase
    end
    return w;
  endfunction

  assign uw = urom(uaddr);
  assign go = !(uw.mode == SQ_WAIT && busy);

  always_comb begin
    case (uw.mode)
      SQ_DISP: uaddr_n = dispatch(opcode);
      SQ_BZ:   uaddr_n = zero ? uw.nxt : '0;
      SQ_WAIT: uaddr_n = busy ? uaddr : uw.nxt;
      default: uaddr_n = uw.nxt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) uaddr <= '0;
    else     uaddr <= uaddr_n;
  end

  a_r1_start_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (uaddr == '0));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (uw.mode == SQ_WAIT && busy) |=> $stable(uaddr));
endmodule

// File: rtl/ucode_bus_core.sv
module ucode_bus_core import ubc_pkg::*; #(
  parameter int            DW       = 32,
  parameter int            NREG     = 32,
  parameter logic [DW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_busy
);
  localparam int IW = $clog2(NREG + 1);

  uword_t        uw;
  logic          go, alu_zero;
  logic [DW-1:0] ir, opa, opb, ma;
  logic [DW-1:0] bus, imm_val, alu_y, rf_q;
  logic [IW-1:0] rf_idx;

  ubc_useq u_seq (
    .clk(clk), .rst(rst), .opcode(ir[31:26]), .zero(alu_zero),
    .busy(mem_busy), .uw(uw), .go(go)
  );

  ubc_alu #(.DW(DW)) u_alu (
    .a(opa), .b(opb), .op(uw.alu_op), .y(alu_y), .zero(alu_zero)
  );

  always_comb begin
    case (uw.rsel)
      RS_RD:   rf_idx = IW'(ir[15:11]);
      RS_RT:   rf_idx = IW'(ir[20:16]);
      RS_RS:   rf_idx = IW'(ir[25:21]);
      RS_LINK: rf_idx = IW'(NREG - 1);
      default: rf_idx = IW'(NREG);
    endcase
  end

  ubc_regfile #(.DW(DW), .NREG(NREG), .RESET_PC(RESET_PC)) u_rf (
    .clk(clk), .rst(rst), .idx(rf_idx), .wr_en(uw.reg_wr && go),
    .wr_data(bus), .rd_data(rf_q)
  );

  always_comb begin
    case (uw.ext)
      EX_SEXT: imm_val = {{(DW-16){ir[15]}}, ir[15:0]};
      EX_ZEXT: imm_val = {{(DW-16){1'b0}}, ir[15:0]};
      EX_SHL2: imm_val = {{(DW-18){ir[15]}}, ir[15:0], 2'b00};
      default: imm_val = DW'(4);
    endcase
  end

  // shared bus: the control word enables one source per cycle
  always_comb begin
    bus = '0;
    if (uw.en_imm) bus = imm_val;
    if (uw.en_alu) bus = alu_y;
    if (uw.en_reg) bus = rf_q;
    if (uw.en_mem) bus = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir <= '0; opa <= '0; opb <= '0; ma <= '0;
    end else if (go) begin
      if (uw.ld_ir) ir  <= bus;
      if (uw.ld_a)  opa <= bus;
      if (uw.ld_b)  opb <= bus;
      if (uw.ld_ma) ma  <= bus;
    end
  end

  assign mem_req   = uw.en_mem || uw.mem_wr;
  assign mem_we    = uw.mem_wr;
  assign mem_addr  = ma;
  assign mem_wdata = bus;

  a_r9_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0({uw.en_imm, uw.en_alu, uw.en_reg, uw.en_mem}));

  a_r7_request_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_busy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/ucode_bus_core_test.sv
`timescale 1ns/1ps
module ucode_bus_core_test;
  localparam logic [31:0] HALT = 32'h1000FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we, mem_busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int total = 0, bad = 0, cyc = 0, nfetch = 0, busy_mode = 0;
  int fetch_t [8];
  logic [31:0] first_addr;
  bit done = 0;

  logic [31:0] mem     [256];
  logic [31:0] img     [256];
  logic [31:0] sim_mem [256];
  logic [31:0] iss_reg [32];

  always #4 clk = ~clk;

  ucode_bus_core uut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_busy(mem_busy)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  initial mem_busy = 1'b0;
  always @(negedge clk) mem_busy <= (busy_mode != 0) ? (($urandom % 3) == 0) : 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && mem_req && !mem_busy) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else begin
        if (nfetch == 0) first_addr = mem_addr;
        if (nfetch < 8) fetch_t[nfetch] = cyc;
        nfetch = nfetch + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int op, input int rs, input int rt, input int rd);
    return {6'(op), 5'(rs), 5'(rt), 5'(rd), 11'd0};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic iss_run();
    logic [31:0] pc, ins, a, b, res;
    int rdi, rti;
    for (int i = 0; i < 256; i++) sim_mem[i] = img[i];
    for (int i = 0; i < 32; i++) iss_reg[i] = '0;
    pc = '0;
    for (int s = 0; s < 2000; s++) begin
      ins = sim_mem[pc[9:2]];
      if (ins == HALT) break;
      pc  = pc + 4;
      a   = iss_reg[ins[25:21]];
      b   = iss_reg[ins[20:16]];
      rdi = int'(ins[15:11]);
      rti = int'(ins[20:16]);
      res = 'x;
      case (ins[31:26])
        6'd0:  begin res = a + b; if (rdi != 0) iss_reg[rdi] = res; end
        6'd1:  begin res = a - b; if (rdi != 0) iss_reg[rdi] = res; end
        6'd2:  begin res = a & b; if (rdi != 0) iss_reg[rdi] = res; end
        6'd3:  begin res = a | b; if (rdi != 0) iss_reg[rdi] = res; end
        6'd8:  begin res = a + sx(ins[15:0]); if (rti != 0) iss_reg[rti] = res; end
        6'd4:  if (a == b) pc = pc + {sx(ins[15:0])[29:0], 2'b00};
        6'd43: begin res = a + sx(ins[15:0]); sim_mem[res[9:2]] = b; end
        6'd35: begin res = a + sx(ins[15:0]); if (rti != 0) iss_reg[rti] = sim_mem[res[9:2]]; end
        default: ;
      endcase
    end
  endtask

  // dump r0..r7 to 0x300 and stop on a self-jump
  task automatic put_dump(input int at);
    for (int i = 0; i < 8; i++) img[at + i] = enc_i(43, 0, i, 32'h300 + 4 * i);
    img[at + 8] = HALT;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = '0;
  endtask

  task automatic run_prog(input int bmode, input int cycles);
    for (int i = 0; i < 256; i++) mem[i] = img[i];
    busy_mode = bmode;
    rst = 1'b1;
    nfetch = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 req low in reset", {31'd0, mem_req}, 32'd0);
    chk("R1 we low in reset", {31'd0, mem_we}, 32'd0);
    rst = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    chk("R1 first fetch address", first_addr, 32'd0);
  endtask

  task automatic compare_all(input string tag);
    iss_run();
    for (int i = 0; i < 8; i++)
      chk($sformatf("%s R2 R3 R4 R5 R9 reg r%0d", tag, i), mem[192 + i], iss_reg[i]);
    for (int j = 0; j < 16; j++)
      chk($sformatf("%s R6 data word %0d", tag, j), mem[128 + j], sim_mem[128 + j]);
  endtask

  task automatic gen_random();
    int kind, off;
    clear_img();
    for (int j = 0; j < 16; j++) img[128 + j] = $urandom;
    for (int p = 0; p < 24; p++) begin
      kind = $urandom % 8;
      case (kind)
        0, 1, 2, 3: img[p] = enc_r(kind, $urandom % 8, $urandom % 8, $urandom % 8);
        4: img[p] = enc_i(8, $urandom % 8, $urandom % 8, $urandom % 65536);
        5: begin
          off = $urandom % 3;
          if (off > 23 - p) off = 23 - p;
          img[p] = enc_i(4, $urandom % 8, $urandom % 8, off);
        end
        6: img[p] = enc_i(43, 0, $urandom % 8, 32'h200 + 4 * ($urandom % 16));
        default: img[p] = enc_i(35, 0, $urandom % 8, 32'h200 + 4 * ($urandom % 16));
      endcase
    end
    put_dump(24);
  endtask

  initial begin
    void'($urandom(32'd2024));

    // directed corners: -1, writes to r0, sign boundary, taken and untaken branches
    clear_img();
    img[0]  = enc_i(8, 0, 1, 16'hFFFF);   // r1 = -1 (R3)
    img[1]  = enc_i(8, 0, 0, 5);          // r0 write discarded (R4)
    img[2]  = enc_r(0, 1, 1, 0);          // r0 write discarded (R4)
    img[3]  = enc_r(0, 1, 1, 2);          // r2 = -2 (R2)
    img[4]  = enc_r(1, 0, 1, 3);          // r3 = 1 (R2)
    img[5]  = enc_r(2, 1, 3, 4);          // r4 = 1
    img[6]  = enc_r(3, 2, 3, 5);          // r5 = -1
    img[7]  = enc_i(4, 5, 1, 1);          // taken, skips next (R5)
    img[8]  = enc_i(8, 0, 6, 99);
    img[9]  = enc_i(4, 2, 3, 1);          // not taken (R5)
    img[10] = enc_i(8, 0, 7, 16'h7FFF);
    img[11] = enc_i(43, 0, 7, 32'h200);   // (R6)
    img[12] = enc_i(35, 0, 6, 32'h200);   // (R6)
    put_dump(13);
    run_prog(1, 2500);
    compare_all("directed busy R7");
    chk("R4 r0 stays zero", mem[192], 32'd0);
    chk("R5 skipped addi left r6 from load", mem[198], 32'h00007FFF);

    // timing: back-to-back add-immediate and register ops with memory never busy
    clear_img();
    img[0] = enc_i(8, 0, 1, 3);
    img[1] = enc_r(0, 1, 1, 2);
    img[2] = enc_r(1, 2, 1, 3);
    img[3] = enc_r(3, 2, 3, 4);
    put_dump(4);
    run_prog(0, 600);
    chk("R8 addi fetch spacing", 32'(fetch_t[1] - fetch_t[0]), 32'd7);
    chk("R8 add fetch spacing", 32'(fetch_t[2] - fetch_t[1]), 32'd7);
    chk("R8 sub fetch spacing", 32'(fetch_t[3] - fetch_t[2]), 32'd7);
    compare_all("timing");

    // random programs, each run without and with a random busy pattern
    for (int n = 0; n < 6; n++) begin
      gen_random();
      run_prog(0, 1500);
      compare_all($sformatf("rand%0d nobusy", n));
      run_prog(1, 2500);
      compare_all($sformatf("rand%0d busy R7", n));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule